// File: doc/BRIEF.md
# DMA-In Byte Loader Sequencer

This block feeds a buffer of bytes into a processor's memory through the processor's DMA-input request line. It does the job that a bank of hand-set data switches and a load button used to do. A start pulse and a length begin a transfer. The sequencer reads each byte from a local buffer through a simple read port and drives it onto the processor's data bus. It waits a settle time and then raises the DMA request. It then watches the processor's two-bit state code until the DMA state appears.

Once the DMA state is seen, the request is dropped. The data bus is enabled only while the processor sits in the DMA state. The sequencer waits for the state code to leave the DMA state before it moves on to the next byte. The processor keeps its own write address and increments it after each write, so the loader has no address output towards the target memory. Its buffer index is visible on the read port. When the last byte's DMA cycle has ended, the sequencer pulses `done` for one cycle and returns to idle with the index at zero.

Top module: `dma_byte_loader`

## Requirements
- R1: While and just after reset, `busy`, `done`, `dma_req` and `bus_oe` are low and `buf_addr` is zero.
- R2: Only the state code `sc_in` = 2'b10 (bit 1 set, bit 0 clear) counts as the DMA state. The codes 2'b00, 2'b01 and 2'b11 leave a raised request in place.
- R3: `bus_data` holds the current byte unchanged for at least `SETTLE_CYC` clock cycles (default 4) before `dma_req` rises.
- R4: `dma_req` is dropped after the DMA state is seen. Each byte gets exactly one request pulse, so the processor performs exactly one DMA write per byte.
- R5: A new byte, and its request, is not started until the synchronized state code has left the DMA state.
- R6: `bus_oe` is high only while the synchronized state code shows the DMA state during a handshake. Because of the synchronizer, it lags `sc_in` by two cycles.
- R7: The bytes reach the processor in index order 0 to `len`-1. Each byte carries the value that `buf_data` returns for that index on `buf_addr`.
- R8: During a transfer, `buf_addr` equals the index of the byte being transferred. It reads zero once `done` has been issued.
- R9: A start with `len` = 0 raises `done` in the next cycle and issues no request.
- R10: A start pulse that arrives while `busy` is high is ignored, and the transfer in progress keeps its length.
- R11: `done` is a single-cycle pulse. It is issued only after the last byte's DMA state has ended, and `busy` is low in the same cycle.
- R12: `sc_in` passes through a two-flop synchronizer. `dma_req` therefore falls no earlier than two clock cycles after `sc_in` first shows the DMA state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; sampled only when idle |
| len | input | LEN_W | Number of bytes to transfer |
| buf_addr | output | LEN_W | Buffer read index; equals the current byte index |
| buf_data | input | DATA_W | Buffer read data for `buf_addr` (combinational) |
| bus_data | output | DATA_W | Byte driven towards the processor data bus |
| bus_oe | output | 1 | Data bus drive enable; low means tri-stated |
| dma_req | output | 1 | DMA-input request to the processor |
| sc_in | input | 2 | Processor state code, asynchronous |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The processor model takes a varying latency before it grants DMA. While it waits, it shows the interrupt code 2'b11, so a decoder that treats either set bit as the DMA state would drop the request too early. The model also starts a second DMA write if the request is still high when its DMA cycle ends. A design that did not drop the request in time would therefore produce an extra, unexpected write in the scoreboard. Zero length, a start during a transfer and repeated equal bytes are all exercised. A design with a short settle count, an enable that is not gated by the state code, an index that advances early, or a `done` that fires at the request drop would each break one of the cycle-exact checks.

// File: rtl/dmaload_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes the state code uses 2'b10 for the DMA state.
package dmaload_pkg;
    localparam logic [1:0] SC_DMA = 2'b10;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_FETCH,
        LD_SETTLE,
        LD_REQ,
        LD_EXIT
    } ld_state_t;
endpackage

// File: rtl/dl_sync.sv
// Module: multi-flop synchronizer for a small bus of slow status lines.
// Assumes the lines change slowly relative to clk (state codes last cycles).
// Resets to all zero, which is a non-DMA code.
module dl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Purpose: shift the input one flop further along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[g] <= '0;
            end else if (g == 0) begin
                stg[g] <= d;
            end else begin
                stg[g] <= stg[(g > 0) ? g - 1 : 0];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dl_settle.sv
// Module: settle timer. A load starts a countdown of CYC cycles.
// expired is high in the cycle in which the CYC-th cycle after the load completes.
// Assumes CYC >= 1.
module dl_settle #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt;

    // Purpose: load the countdown, or count towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == CW'(1)) && !load;

    initial begin
        a_r3_cyc_positive: assert (CYC >= 1);
    end
endmodule

// File: rtl/dma_byte_loader.sv
// Module: DMA-in byte loader sequencer (top).
// Streams len bytes from a local buffer into a processor by a four-phase
// handshake: drive data, settle, raise request, see the DMA state code,
// drop request, see the state code leave DMA, go to the next byte.
// Assumes buf_data is a combinational read of buf_addr and that the processor
// keeps its own write address.
module dma_byte_loader
    import dmaload_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int DATA_W      = 8,
    parameter int SETTLE_CYC  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    output logic [LEN_W-1:0]  buf_addr,
    input  logic [DATA_W-1:0] buf_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              dma_req,
    input  logic [1:0]        sc_in,
    output logic              busy,
    output logic              done
);
    ld_state_t         state;
    logic [LEN_W-1:0]  idx;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] data_q;
    logic [1:0]        sc_s;
    logic              in_dma;
    logic              settle_done;
    logic              last_byte;

    dl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sc_in),
        .q     (sc_s)
    );

    dl_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state == LD_FETCH),
        .expired (settle_done)
    );

    assign in_dma    = (sc_s == SC_DMA);
    assign last_byte = (idx == len_q - LEN_W'(1));

    // Purpose: handshake sequencing, byte index and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= LD_IDLE;
            idx     <= '0;
            len_q   <= '0;
            data_q  <= '0;
            dma_req <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                LD_IDLE: begin
                    if (start) begin
                        if (len == '0) begin
                            done <= 1'b1;
                        end else begin
                            len_q <= len;
                            idx   <= '0;
                            state <= LD_FETCH;
                        end
                    end
                end
                LD_FETCH: begin
                    data_q <= buf_data;
                    state  <= LD_SETTLE;
                end
                LD_SETTLE: begin
                    if (settle_done) begin
                        dma_req <= 1'b1;
                        state   <= LD_REQ;
                    end
                end
                LD_REQ: begin
                    if (in_dma) begin
                        dma_req <= 1'b0;
                        state   <= LD_EXIT;
                    end
                end
                LD_EXIT: begin
                    if (!in_dma) begin
                        if (last_byte) begin
                            done  <= 1'b1;
                            idx   <= '0;
                            state <= LD_IDLE;
                        end else begin
                            idx   <= idx + LEN_W'(1);
                            state <= LD_FETCH;
                        end
                    end
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    assign busy     = (state != LD_IDLE);
    assign buf_addr = idx;
    assign bus_data = data_q;
    assign bus_oe   = in_dma && ((state == LD_REQ) || (state == LD_EXIT));

    // R4: seeing the DMA state while requesting drops the request next cycle.
    a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && in_dma) |=> !dma_req);

    // R5: the byte index never moves while the processor is in DMA.
    a_r5_hold_in_dma: assert property (@(posedge clk) disable iff (!rst_n)
        in_dma |=> $stable(idx));

    // R3: data is stable on the cycle the request rises.
    a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $stable(bus_data));

    // R9: a zero length finishes at once without a request.
    a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len == '0) |=> (done && !dma_req && !busy));

    // R10: start while busy leaves the latched length untouched.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(len_q));

    // R11: done lasts one cycle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the index stays inside the transfer.
    a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx < len_q));
endmodule

// File: tb/dma_byte_loader_test.sv
// Bench: scoreboard against a small processor model that shows state codes.
module dma_byte_loader_test;
    localparam int LEN_W  = 8;
    localparam int DATA_W = 8;
    localparam int SETTLE = 4;
    localparam int DUR    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0]  len = '0;
    logic [LEN_W-1:0]  buf_addr;
    logic [DATA_W-1:0] buf_data;
    logic [DATA_W-1:0] bus_data;
    logic bus_oe, dma_req, busy, done;
    logic [1:0] sc_in = 2'b00;

    logic [7:0] mem [256];
    logic [7:0] expq [$];

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int req_rise_cnt = 0;
    int xfer_base = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    assign buf_data = mem[buf_addr];

    dma_byte_loader #(.LEN_W(LEN_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len),
        .buf_addr(buf_addr), .buf_data(buf_data), .bus_data(bus_data),
        .bus_oe(bus_oe), .dma_req(dma_req), .sc_in(sc_in),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Processor model and monitor.
    // M_RUN alternates 00/01, M_PEND shows 11 while granting, M_DMA shows 10.
    typedef enum int {M_RUN, M_PEND, M_DMA} mst_t;
    mst_t mstate = M_RUN;
    int pcnt = 0, dcnt = 0, stab = 0;
    logic [1:0] h1 = 2'b00, h2 = 2'b00;
    logic req_prev = 1'b0, done_prev = 1'b0;
    logic [7:0] bd_prev = '0;
    logic [1:0] sc_next;

    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            mstate = M_RUN; sc_in = 2'b00; h1 = 2'b00; h2 = 2'b00;
            req_prev = 1'b0; done_prev = 1'b0; stab = 0; bd_prev = bus_data;
        end else begin
            // Stability of the driven byte, for R3.
            if (bus_data != bd_prev) stab = 0; else stab++;
            bd_prev = bus_data;
            // R6: enable only when the code seen two cycles ago was DMA.
            if (bus_oe) chk(h2 == 2'b10, "R6", "bus_oe without DMA code", h2, 2);
            // Request rising edge: R3, R5, R8.
            if (dma_req && !req_prev) begin
                req_rise_cnt++;
                chk(stab >= SETTLE, "R3", "settle cycles before request", stab, SETTLE);
                chk(h1 != 2'b10 && h2 != 2'b10 && mstate != M_DMA, "R5",
                    "request while still in DMA", h1, 0);
                chk(int'(buf_addr) == req_rise_cnt - 1 - xfer_base, "R8",
                    "buf_addr at request", buf_addr, req_rise_cnt - 1 - xfer_base);
            end
            // Request falling edge: R2 and R12.
            if (!dma_req && req_prev) begin
                chk(mstate != M_PEND, "R2", "request dropped on non-DMA code", 1, 0);
                chk(h2 == 2'b10, "R12", "drop before two sync cycles", h2, 2);
            end
            // Done pulse: R11.
            if (done) begin
                chk(!done_prev, "R11", "done longer than one cycle", 1, 0);
                chk(!busy, "R11", "busy with done", busy, 0);
                chk(mstate != M_DMA && h2 != 2'b10, "R11", "done during DMA", 1, 0);
            end
            req_prev = dma_req;
            done_prev = done;

            // Model step.
            sc_next = sc_in;
            case (mstate)
                M_RUN: begin
                    if (dma_req) begin
                        pcnt = (req_rise_cnt % 3) + 1;
                        mstate = M_PEND;
                        sc_next = 2'b11;
                    end else begin
                        sc_next = (sc_in == 2'b00) ? 2'b01 : 2'b00;
                    end
                end
                M_PEND: begin
                    pcnt--;
                    if (pcnt == 0) begin
                        mstate = M_DMA; dcnt = 0; sc_next = 2'b10;
                    end
                end
                M_DMA: begin
                    dcnt++;
                    if (dcnt == DUR - 1) begin
                        wr_cnt++;
                        chk(bus_oe, "R6", "bus_oe low at DMA write", bus_oe, 1);
                        if (expq.size() == 0) begin
                            chk(1'b0, "R4", "extra DMA write", bus_data, 0);
                        end else begin
                            automatic logic [7:0] e = expq.pop_front();
                            chk(bus_data == e, "R7", "written byte", bus_data, e);
                        end
                        mstate = M_RUN; sc_next = 2'b01;
                    end
                end
                default: mstate = M_RUN;
            endcase
            sc_in = sc_next;
            h2 = h1;
            h1 = sc_next;
        end
        if (cycles > 150000) begin
            chk(1'b0, "WD", "watchdog expired", cycles, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver: fill the buffer, push expected bytes, start, wait for done.
    task automatic run_xfer(input int n, input int seed, input bit poke);
        int rc0, wc0, t;
        for (int i = 0; i < n; i++) begin
            mem[i] = 8'((seed * 37 + i * 13 + i / 3) & 8'hff);
            if (seed == 9) mem[i] = 8'h5a;
            expq.push_back(mem[i]);
        end
        rc0 = req_rise_cnt;
        wc0 = wr_cnt;
        xfer_base = req_rise_cnt;
        @(negedge clk); start = 1'b1; len = LEN_W'(n);
        @(negedge clk); start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R9", "done after zero length", done, 1);
            chk(busy == 1'b0, "R9", "busy after zero length", busy, 0);
            repeat (3) @(negedge clk);
            chk(req_rise_cnt == rc0, "R9", "request on zero length", req_rise_cnt - rc0, 0);
            return;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (poke && t == 10) begin start = 1'b1; len = 8'd3; end
            if (poke && t == 11) start = 1'b0;
        end
        chk(done, "R11", "done seen", done, 1);
        chk(wr_cnt - wc0 == n, "R4", "DMA writes per transfer", wr_cnt - wc0, n);
        chk(req_rise_cnt - rc0 == n, "R4", "request pulses", req_rise_cnt - rc0, n);
        chk(expq.size() == 0, "R7", "bytes left undelivered", expq.size(), 0);
        chk(buf_addr == '0, "R8", "index after done", buf_addr, 0);
        if (poke) chk(wr_cnt - wc0 == n, "R10", "length changed by start while busy",
                      wr_cnt - wc0, n);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done second cycle", done, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !dma_req && !bus_oe && buf_addr == '0, "R1",
            "outputs in reset", {busy, done, dma_req, bus_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !dma_req && !bus_oe && buf_addr == '0, "R1",
            "outputs after reset", {busy, done, dma_req, bus_oe}, 0);
        run_xfer(1, 1, 1'b0);
        run_xfer(5, 2, 1'b0);
        run_xfer(0, 0, 1'b0);
        run_xfer(12, 9, 1'b0);
        run_xfer(6, 4, 1'b1);
        run_xfer(40, 7, 1'b0);
        run_xfer(0, 0, 1'b0);
        run_xfer(2, 3, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule